// File: doc/BRIEF.md
# Guarded Byte Store Write Controller

This block is the register front end of a small byte-addressable nonvolatile data store. An internal register bus reaches four registers: control, key, address and data. Reads of the store are immediate. A read strobe copies the byte at the current address into the data register. A write is accepted only when three conditions hold together. The write-enable bit must already be set. The two-byte unlock key must have been written with no other bus write in between, and the start command must be the next bus write. The power-up lockout period must be over.

Once a write starts, the start bit reads as busy for a fixed number of clock cycles, which is a parameter. The byte lands in the store in the cycle the busy bit drops. The unlock state is used up by every start attempt, so each write needs a new key sequence.

A separate external programming port can read and write the store directly. When code protection is on, that port reads zero and its writes are dropped. Code protection has no effect on the internal bus.

Top module: `nvm_unlock_ctrl`

## Requirements
- R1: After reset, the write-enable bit, the error flag and busy are all 0, the key sequence is idle, and the control register reads 0x00.
- R2: `bus_reg` selects the register: 0 control, 1 key, 2 address, 3 data. `bus_rdata` shows the selected register in the same cycle without a clock edge. The key register reads 0x00. Control bits are: bit0 read strobe (reads 0), bit1 write-enable, bit2 write-start/busy, bit3 write error.
- R3: A control write with bit0 = 1 loads the data register at that clock edge with the store byte at the current address register value.
- R4: Arming requires a key-register write of 0x55 and then a key-register write of 0xAA. Any other bus write in between restarts the sequence. A key write of 0x55 always restarts it at the first step. Once armed, the next bus write must be a control write with bit2 = 1, or the arming is lost.
- R5: A control write with bit2 = 1 and write-enable 1 but without a complete key sequence starts nothing, changes no store byte and leaves the error flag unchanged.
- R6: A control write with bit2 = 1 while the write-enable bit held before that write is 0 starts nothing and sets the error flag. The error flag is cleared by a control write with bit3 = 1.
- R7: During the first PWRUP_CYC clock edges after reset, a start request with write-enable set and the key sequence complete is refused without setting the error flag.
- R8: After an accepted start, bit2 reads 1 for exactly WR_LAT cycles. The latched byte is written to the latched address at the edge where bit2 returns to 0. Start requests made while busy are ignored.
- R9: Any start attempt, accepted or not, clears the unlock state, so a second start needs a new key sequence.
- R10: With `cp_en` = 0, `xp_rdata` shows the store byte at `xp_addr` without a clock edge, and `xp_wr` writes `xp_wdata` at the clock edge unless a write is busy.
- R11: With `cp_en` = 1, `xp_rdata` reads 0 and `xp_wr` is ignored. Internal bus reads and writes work as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Internal bus access this cycle |
| bus_we | input | 1 | Access is a write |
| bus_reg | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Selected register contents |
| cp_en | input | 1 | Code protection of the external port |
| xp_wr | input | 1 | External port write strobe |
| xp_addr | input | 8 | External port address |
| xp_wdata | input | 8 | External port write data |
| xp_rdata | output | 8 | External port read data |

## Verification
The bench tries to start a write while the power-up lockout is still running. A design that ignored the lockout would go busy and change a byte. It breaks the key sequence with an address write, and separately with a data write after arming. A controller that only remembered both keys were seen would then write. It measures the busy window cycle by cycle, which exposes an off-by-one in the latency counter or a store update at the wrong edge. It also repeats a start straight after a finished write with no new keys; a design that kept the unlock state would write twice. Code protection is checked on the external port while internal writes go on.

// File: rtl/nvm_unlock_pkg.sv
package nvm_unlock_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_KEY  = 2'd1,
    REG_ADDR = 2'd2,
    REG_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_HALF  = 2'd1,
    KS_ARMED = 2'd2
  } key_state_e;

  localparam int CB_RD  = 0;
  localparam int CB_WEN = 1;
  localparam int CB_GO  = 2;
  localparam int CB_ERR = 3;

  function automatic logic [3:0] ctrl_image(input logic wen, input logic busy, input logic err);
    logic [3:0] v;
    v = '0;
    v[CB_WEN] = wen;
    v[CB_GO]  = busy;
    v[CB_ERR] = err;
    return v;
  endfunction

  function automatic key_state_e key_step(input key_state_e cur, input logic is_key,
                                          input logic is_other, input logic [7:0] val,
                                          input logic [7:0] first, input logic [7:0] second);
    key_state_e nx;
    nx = cur;
    if (is_key) begin
      if (val == first)                        nx = KS_HALF;
      else if (cur == KS_HALF && val == second) nx = KS_ARMED;
      else                                     nx = KS_IDLE;
    end else if (is_other) begin
      nx = KS_IDLE;
    end
    return nx;
  endfunction

endpackage

// File: rtl/nvm_pwrup_gate.sv
module nvm_pwrup_gate #(
  parameter int CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic lockout_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (cnt_q < CW'(CYC))  cnt_q <= cnt_q + 1'b1;
  end

  assign lockout_o = (cnt_q < CW'(CYC));

  // R7
  lockout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lockout_o |=> !lockout_o);
endmodule

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
  import nvm_unlock_pkg::*;
#(
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr_i,
  input  logic       other_wr_i,
  input  logic [7:0] wdata_i,
  output logic       armed_o
);
  key_state_e st_q, st_d;

  always_comb st_d = key_step(st_q, key_wr_i, other_wr_i, wdata_i, KEY_A, KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign armed_o = (st_q == KS_ARMED);

  // R4
  arm_needs_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> ($past(key_wr_i) && $past(wdata_i) == KEY_B));

  // R4
  arm_lost_on_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    other_wr_i |=> !armed_o);
endmodule

// File: rtl/nvm_write_engine.sv
module nvm_write_engine #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LAT    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] c_addr_o,
  output logic [DATA_W-1:0] c_data_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      c_addr_o <= '0;
      c_data_o <= '0;
    end else if (start_i && cnt_q == '0) begin
      cnt_q    <= CW'(LAT);
      c_addr_o <= addr_i;
      c_data_o <= data_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign commit_o = (cnt_q == CW'(1));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !commit_o) |=> busy_o);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !busy_o);

  // R8
  latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !commit_o) |=> $stable(c_addr_o) && $stable(c_data_o));
endmodule

// File: rtl/nvm_byte_array.sv
module nvm_byte_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_en,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wa_en) begin
      mem[wa_addr] <= wa_data;
    end else if (wb_en) begin
      mem[wb_addr] <= wb_data;
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];

  // R10
  single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_en && wb_en));
endmodule

// File: rtl/nvm_unlock_ctrl.sv
module nvm_unlock_ctrl
  import nvm_unlock_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter int         WR_LAT    = 6,
  parameter int         PWRUP_CYC = 32,
  parameter logic [7:0] KEY_A     = 8'h55,
  parameter logic [7:0] KEY_B     = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_reg,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cp_en,
  input  logic              xp_wr,
  input  logic [ADDR_W-1:0] xp_addr,
  input  logic [DATA_W-1:0] xp_wdata,
  output logic [DATA_W-1:0] xp_rdata
);
  localparam int PAD_W = DATA_W - 4;

  reg_sel_e          sel;
  logic              bus_wr, wr_ctrl, wr_key, wr_addr, wr_data, wr_other;
  logic              go_req, start_go, start_refused;
  logic              armed, lockout, busy, commit;
  logic              wen_q, werr_q;
  logic [ADDR_W-1:0] addr_q, c_addr;
  logic [DATA_W-1:0] data_q, c_data, int_rd, ext_rd;
  logic              xp_wr_ok;

  assign sel      = reg_sel_e'(bus_reg);
  assign bus_wr   = bus_sel && bus_we;
  assign wr_ctrl  = bus_wr && sel == REG_CTRL;
  assign wr_key   = bus_wr && sel == REG_KEY;
  assign wr_addr  = bus_wr && sel == REG_ADDR;
  assign wr_data  = bus_wr && sel == REG_DATA;
  assign wr_other = bus_wr && !wr_key;

  assign go_req        = wr_ctrl && bus_wdata[CB_GO];
  assign start_refused = go_req && !busy && !wen_q;
  assign start_go      = go_req && !busy && wen_q && armed && !lockout;

  nvm_pwrup_gate #(.CYC(PWRUP_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .lockout_o(lockout)
  );

  nvm_key_seq #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk(clk), .rst_n(rst_n), .key_wr_i(wr_key), .other_wr_i(wr_other),
    .wdata_i(bus_wdata[7:0]), .armed_o(armed)
  );

  nvm_write_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(WR_LAT)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(start_go), .addr_i(addr_q), .data_i(data_q),
    .busy_o(busy), .commit_o(commit), .c_addr_o(c_addr), .c_data_o(c_data)
  );

  assign xp_wr_ok = xp_wr && !cp_en && !busy;

  nvm_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .wa_en(commit), .wa_addr(c_addr), .wa_data(c_data),
    .wb_en(xp_wr_ok), .wb_addr(xp_addr), .wb_data(xp_wdata),
    .ra_addr(addr_q), .ra_data(int_rd),
    .rb_addr(xp_addr), .rb_data(ext_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q  <= 1'b0;
      werr_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_ctrl) wen_q <= bus_wdata[CB_WEN];
      werr_q <= (werr_q && !(wr_ctrl && bus_wdata[CB_ERR])) || start_refused;
      if (wr_addr) addr_q <= bus_wdata[ADDR_W-1:0];
      if (wr_data)                          data_q <= bus_wdata;
      else if (wr_ctrl && bus_wdata[CB_RD]) data_q <= int_rd;
    end
  end

  always_comb begin
    unique case (sel)
      REG_CTRL: bus_rdata = {{PAD_W{1'b0}}, ctrl_image(wen_q, busy, werr_q)};
      REG_KEY:  bus_rdata = '0;
      REG_ADDR: bus_rdata = DATA_W'(addr_q);
      default:  bus_rdata = data_q;
    endcase
  end

  assign xp_rdata = cp_en ? '0 : ext_rd;

  // R1
  wen_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!wen_q && !werr_q && !busy));

  // R6
  refused_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_refused |=> werr_q);

  // R7
  no_start_in_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(lockout));

  // R4
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));

  // R9
  unlock_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_req |=> !armed);
endmodule

// File: tb/sim_nvm_unlock_ctrl.sv
module sim_nvm_unlock_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WR_LAT     = 6;
  localparam int PWRUP      = 32;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_sel = 0, bus_we = 0;
  logic [1:0] bus_reg = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       cp_en = 0, xp_wr = 0;
  logic [7:0] xp_addr = 0, xp_wdata = 0, xp_rdata;

  int checks = 0, errors = 0;

  nvm_unlock_ctrl #(.ADDR_W(8), .DATA_W(8), .WR_LAT(WR_LAT), .PWRUP_CYC(PWRUP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_reg(bus_reg),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cp_en(cp_en), .xp_wr(xp_wr),
    .xp_addr(xp_addr), .xp_wdata(xp_wdata), .xp_rdata(xp_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [7:0] m_mem [256];
  logic [7:0] m_addr = 0, m_dreg = 0, m_baddr = 0, m_bdata = 0;
  logic       m_wen = 0, m_werr = 0;
  int         m_key = 0, m_bcnt = 0, m_pcnt = 0;

  initial for (int i = 0; i < 256; i++) m_mem[i] = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_mem[i] = 0;
      m_addr = 0; m_dreg = 0; m_wen = 0; m_werr = 0; m_key = 0; m_bcnt = 0; m_pcnt = 0;
    end else begin
      automatic bit   was_busy = (m_bcnt != 0);
      automatic bit   was_wen  = m_wen;
      automatic bit   locked   = (m_pcnt < PWRUP);
      automatic int   key_pre  = m_key;
      automatic logic [7:0] dpre = m_dreg;
      automatic logic [7:0] rdv  = m_mem[m_addr];
      automatic bit   err = 0;
      if (locked) m_pcnt++;
      if (m_bcnt == 1) m_mem[m_baddr] = m_bdata;
      if (m_bcnt != 0) m_bcnt--;
      if (xp_wr && !cp_en && !was_busy) m_mem[xp_addr] = xp_wdata;
      if (bus_sel && bus_we) begin
        case (bus_reg)
          2'd0: begin
            if (bus_wdata[2] && !was_busy) begin
              if (!was_wen) err = 1;
              else if (key_pre == 2 && !locked) begin
                m_bcnt = WR_LAT; m_baddr = m_addr; m_bdata = dpre;
              end
            end
            if (bus_wdata[0]) m_dreg = rdv;
            m_wen  = bus_wdata[1];
            m_werr = (m_werr && !bus_wdata[3]) || err;
            m_key  = 0;
          end
          2'd1: m_key = (bus_wdata == 8'h55) ? 1 : ((key_pre == 1 && bus_wdata == 8'hAA) ? 2 : 0);
          2'd2: begin m_addr = bus_wdata; m_key = 0; end
          default: begin m_dreg = bus_wdata; m_key = 0; end
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic [7:0] exp_bus;
      automatic logic [7:0] exp_xp = cp_en ? 8'h00 : m_mem[xp_addr];
      case (bus_reg)
        2'd0: exp_bus = {4'b0, m_werr, (m_bcnt != 0), m_wen, 1'b0};
        2'd1: exp_bus = 8'h00;
        2'd2: exp_bus = m_addr;
        default: exp_bus = m_dreg;
      endcase
      checks++;
      if (bus_rdata !== exp_bus) begin
        errors++;
        $display("FAIL R2 model bus_rdata reg %0d act %h exp %h at %0t", bus_reg, bus_rdata, exp_bus, $time);
      end
      checks++;
      if (xp_rdata !== exp_xp) begin
        errors++;
        $display("FAIL R10 model xp_rdata act %h exp %h at %0t", xp_rdata, exp_xp, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] r, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_reg = r; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic peek(input logic [1:0] r, output logic [7:0] v);
    bus_reg = r; #2; v = bus_rdata;
  endtask

  task automatic xpeek(input logic [7:0] a, output logic [7:0] v);
    xp_addr = a; #1; v = xp_rdata;
  endtask

  task automatic keys();
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    idle(3);
    rst_n = 1;
    #1;
    // R1 reset state
    peek(2'd0, v); chk("R1 ctrl after reset", v, 8'h00);

    // R7 start inside power-up lockout
    wr(2'd2, 8'h05); wr(2'd3, 8'h3C); wr(2'd0, 8'h02); keys(); wr(2'd0, 8'h06);
    peek(2'd0, v); chk("R7 lockout start refused, no error", v, 8'h02);
    idle(WR_LAT + 2);
    xpeek(8'h05, v); chk("R7 lockout byte unchanged", v, 8'h00);
    idle(PWRUP + 4);

    // R6 start with write-enable clear
    wr(2'd0, 8'h00); keys(); wr(2'd0, 8'h04);
    peek(2'd0, v); chk("R6 error flag set", v, 8'h08);
    idle(WR_LAT + 1);
    xpeek(8'h05, v); chk("R6 byte unchanged", v, 8'h00);
    wr(2'd0, 8'h08);
    peek(2'd0, v); chk("R6 error cleared by bit3", v, 8'h00);

    // R5 start without keys
    wr(2'd0, 8'h02); wr(2'd0, 8'h06);
    peek(2'd0, v); chk("R5 no busy, no error", v, 8'h02);

    // R4 broken sequences
    wr(2'd1, 8'h55); wr(2'd2, 8'h05); wr(2'd1, 8'hAA); wr(2'd0, 8'h06);
    peek(2'd0, v); chk("R4 address write breaks keys", v, 8'h02);
    keys(); wr(2'd3, 8'h3C); wr(2'd0, 8'h06);
    peek(2'd0, v); chk("R4 data write after arming breaks", v, 8'h02);
    idle(WR_LAT + 1);
    xpeek(8'h05, v); chk("R5 byte unchanged", v, 8'h00);

    // R8 accepted write and busy window
    keys(); wr(2'd0, 8'h06);
    n = 0;
    peek(2'd0, v);
    while (v[2] && n < 100) begin
      if (n == 1) begin
        wr(2'd0, 8'h02);         // bit2 clear must not end busy
        xp_wr = 1; xp_addr = 8'h07; xp_wdata = 8'hEE;
        @(posedge clk); #1; xp_wr = 0;
        n = n + 2;
      end else begin
        n++;
        idle(1);
      end
      peek(2'd0, v);
    end
    chk("R8 busy cycles", 8'(n), 8'(WR_LAT));
    xpeek(8'h05, v); chk("R8 byte written", v, 8'h3C);
    xpeek(8'h07, v); chk("R10 xp write during busy ignored", v, 8'h00);

    // R9 no reuse of the unlock state
    wr(2'd2, 8'h09); wr(2'd0, 8'h06);
    peek(2'd0, v); chk("R9 second start refused", v, 8'h02);
    idle(WR_LAT + 1);
    xpeek(8'h09, v); chk("R9 byte unchanged", v, 8'h00);

    // R3 read strobe
    wr(2'd2, 8'h05); wr(2'd0, 8'h03);
    peek(2'd3, v); chk("R3 read strobe data", v, 8'h3C);
    peek(2'd1, v); chk("R2 key reads zero", v, 8'h00);
    peek(2'd2, v); chk("R2 address readback", v, 8'h05);

    // R10 external port
    xp_wr = 1; xp_addr = 8'h14; xp_wdata = 8'hA5; @(posedge clk); #1; xp_wr = 0;
    xpeek(8'h14, v); chk("R10 xp read back", v, 8'hA5);
    wr(2'd2, 8'h14); wr(2'd0, 8'h03);
    peek(2'd3, v); chk("R10 internal sees xp byte", v, 8'hA5);

    // R11 code protection
    cp_en = 1;
    xpeek(8'h14, v); chk("R11 protected read zero", v, 8'h00);
    xp_wr = 1; xp_addr = 8'h15; xp_wdata = 8'h11; @(posedge clk); #1; xp_wr = 0;
    wr(2'd2, 8'h16); wr(2'd3, 8'h77); keys(); wr(2'd0, 8'h06);
    idle(WR_LAT + 1);
    wr(2'd0, 8'h03);
    peek(2'd3, v); chk("R11 internal write under protection", v, 8'h77);
    cp_en = 0;
    xpeek(8'h15, v); chk("R11 protected xp write dropped", v, 8'h00);
    xpeek(8'h16, v); chk("R11 internal byte visible", v, 8'h77);

    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule